// File: doc/BRIEF.md
# Flash Block Erase Controller

This block sits between a host write/read bus and a small multi-block flash array model. It decodes a two-write erase command, checks the block's lock bit and the programming-supply flag, and then runs a fixed three-phase erase. The first phase drives every word of the block to zero. The second phase drives every word to all ones. The third phase confirms that every word reads all ones. A status word reports completion and any fault. The host polls that word to learn when the operation ends and whether it succeeded.

The array is split into partitions along its upper address bits, and each partition has its own read mode: array data, status word, or information (which reads zero here). A confirmed erase switches the target block's partition to status output. While an erase runs, the controller accepts only read-mode commands and the suspend opcode, and it drops every other write. The length of each phase is a parameter counted in clock cycles.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Writing 0020h to any address and then 00D0h to an address inside block B starts an erase of B. B is taken from the upper address bits of the second write. The status word reads bit 7 (ready) = 0 from the cycle after that write until the erase ends. Status word layout: bit 7 ready, bit 5 erase failure, bit 4 command sequence error, bit 3 supply fault, bit 1 lock fault; all other bits read 0.
- R2: The erase spends PRE_CYC cycles in precondition, ERS_CYC cycles in erase and VFY_CYC cycles in verify, in that order. The block reads all 0000h after precondition. Ready returns exactly PRE_CYC+ERS_CYC+VFY_CYC cycles after the confirm edge.
- R3: After an erase with no fault, every word of the target block reads FFFFh, words of other blocks keep their values, and the status word reads 0080h.
- R4: If the target block's lock bit is high in a busy cycle, the erase aborts at that edge. With the lock high at confirm, ready returns one cycle after the confirm edge, bits 1 and 5 are set, and the array is unchanged.
- R5: If vpp_ok is low in any busy cycle, the erase aborts at that edge and sets bits 3 and 5.
- R6: A setup write followed by any value other than 00D0h sets bits 4 and 5 and erases nothing. A confirm written while prog_susp is high does the same and does not go busy.
- R7: After reset every partition reads array data. 00FFh selects array mode, 0070h selects status mode, and 0090h or 0098h selects information mode (which reads 0000h). Each of these changes only the partition that holds the write address. A confirm switches the target partition to status mode.
- R8: While busy, only 00FFh, 0070h, 0090h, 0098h and 00B0h are accepted. 0050h, 0020h and 00D0h are ignored: error bits are not cleared and no second erase starts.
- R9: Error bits stay set across later erases until a 0050h write while idle, which clears bits 5, 4, 3 and 1.
- R10: After reset, the word at flat index i reads (A5C3h XOR i*0111h), truncated to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write address |
| wr_data | input | 16 | Host write data / command |
| rd_addr | input | AW | Host read address |
| rd_data | output | 16 | Read data, chosen by the addressed partition's mode |
| blk_lock | input | NUM_BLOCKS | Per-block lock bits |
| vpp_ok | input | 1 | Programming supply valid |
| prog_susp | input | 1 | A program suspend is active |

## Verification
On every cycle, the assertions check the abort rules for supply and lock, the sequence-error response, that a clear is ignored while busy and takes effect while idle, the phase counter bound and the precondition-before-erase order. Other behaviours only the bench scenarios can show. These are the exact busy length, the all-zero middle state of the block, the final all-ones contents beside untouched neighbours, and the per-partition read modes. The bench sweeps every array word after each operation and compares it against a model computed from the reset formula.

// File: rtl/erase_pkg.sv
`timescale 1ns/1ps
package erase_pkg;
    localparam int DW = 16;

    typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_ERS, PH_VFY} phase_e;
    typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_INFO} rmode_e;

    localparam logic [DW-1:0] CMD_RD_ARRAY  = 16'h00FF;
    localparam logic [DW-1:0] CMD_RD_STATUS = 16'h0070;
    localparam logic [DW-1:0] CMD_RD_INFO   = 16'h0090;
    localparam logic [DW-1:0] CMD_QUERY     = 16'h0098;
    localparam logic [DW-1:0] CMD_CLEAR     = 16'h0050;
    localparam logic [DW-1:0] CMD_SETUP     = 16'h0020;
    localparam logic [DW-1:0] CMD_CONFIRM   = 16'h00D0;
    localparam logic [DW-1:0] CMD_SUSPEND   = 16'h00B0;
endpackage

// File: rtl/erase_array.sv
`timescale 1ns/1ps
module erase_array #(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_WORDS = 8,
    parameter logic [15:0] INIT_SEED = 16'hA5C3,
    localparam int WORDS = NUM_BLOCKS * BLOCK_WORDS,
    localparam int AW    = $clog2(WORDS),
    localparam int BKW   = $clog2(NUM_BLOCKS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fill_en,
    input  logic [BKW-1:0] fill_blk,
    input  logic [15:0]    fill_val,
    input  logic [AW-1:0]  rd_addr,
    output logic [15:0]    rd_data,
    input  logic [BKW-1:0] chk_blk,
    output logic           chk_ones
);
    typedef struct packed {
        logic [WORDS-1:0][15:0] mem;
    } arr_t;

    arr_t st_d, st_q;

    function automatic logic [15:0] seed_word(input int idx);
        logic [31:0] prod;
        prod = 32'(idx) * 32'h0000_0111;
        return INIT_SEED ^ prod[15:0];
    endfunction

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WORDS; i++) begin
            if (fill_en && (BKW'(i / BLOCK_WORDS) == fill_blk)) begin
                st_d.mem[i] = fill_val;
            end
        end
    end

    always_comb begin
        chk_ones = 1'b1;
        for (int i = 0; i < WORDS; i++) begin
            if ((BKW'(i / BLOCK_WORDS) == chk_blk) && (st_q.mem[i] != 16'hFFFF)) begin
                chk_ones = 1'b0;
            end
        end
    end

    assign rd_data = st_q.mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                st_q.mem[i] <= seed_word(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    ones_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_val == 16'hFFFF && chk_blk == fill_blk) |=> chk_ones);
endmodule

// File: rtl/erase_seq.sv
`timescale 1ns/1ps
module erase_seq
    import erase_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    parameter int PRE_CYC    = 4,
    parameter int ERS_CYC    = 6,
    parameter int VFY_CYC    = 3,
    localparam int BKW  = $clog2(NUM_BLOCKS),
    localparam int MAXC = (PRE_CYC > ERS_CYC) ? ((PRE_CYC > VFY_CYC) ? PRE_CYC : VFY_CYC)
                                              : ((ERS_CYC > VFY_CYC) ? ERS_CYC : VFY_CYC),
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [BKW-1:0]        start_blk_i,
    input  logic                  vpp_ok_i,
    input  logic [NUM_BLOCKS-1:0] lock_i,
    input  logic                  blk_ones_i,
    output logic                  busy_o,
    output logic [BKW-1:0]        blk_o,
    output logic                  done_o,
    output logic                  err_vpp_o,
    output logic                  err_lock_o,
    output logic                  err_vfy_o,
    output logic                  fill_en_o,
    output logic [15:0]           fill_val_o
);
    typedef struct packed {
        phase_e         phase;
        logic [CW-1:0]  cnt;
        logic [BKW-1:0] blk;
    } seq_t;

    seq_t st_d, st_q;
    logic [CW-1:0] len_m1;

    always_comb begin
        case (st_q.phase)
            PH_PRE:  len_m1 = CW'(PRE_CYC - 1);
            PH_ERS:  len_m1 = CW'(ERS_CYC - 1);
            default: len_m1 = CW'(VFY_CYC - 1);
        endcase
    end

    always_comb begin
        st_d       = st_q;
        done_o     = 1'b0;
        err_vpp_o  = 1'b0;
        err_lock_o = 1'b0;
        err_vfy_o  = 1'b0;
        fill_en_o  = 1'b0;
        fill_val_o = 16'h0000;
        if (st_q.phase == PH_IDLE) begin
            if (start_i) begin
                st_d.phase = PH_PRE;
                st_d.cnt   = '0;
                st_d.blk   = start_blk_i;
            end
        end else if (!vpp_ok_i || lock_i[st_q.blk]) begin
            done_o     = 1'b1;
            err_vpp_o  = !vpp_ok_i;
            err_lock_o = lock_i[st_q.blk];
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else if (st_q.cnt != len_m1) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
            case (st_q.phase)
                PH_PRE: begin
                    fill_en_o  = 1'b1;
                    fill_val_o = 16'h0000;
                    st_d.phase = PH_ERS;
                end
                PH_ERS: begin
                    fill_en_o  = 1'b1;
                    fill_val_o = 16'hFFFF;
                    st_d.phase = PH_VFY;
                end
                default: begin
                    done_o     = 1'b1;
                    err_vfy_o  = !blk_ones_i;
                    st_d.phase = PH_IDLE;
                end
            endcase
        end
    end

    assign busy_o = (st_q.phase != PH_IDLE);
    assign blk_o  = st_q.blk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, blk: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.cnt <= len_m1));

    // R2
    pre_before_ers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ERS && $past(st_q.phase) != PH_ERS) |-> ($past(st_q.phase) == PH_PRE));
endmodule

// File: rtl/flash_erase_ctrl.sv
`timescale 1ns/1ps
module flash_erase_ctrl
    import erase_pkg::*;
#(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_WORDS = 8,
    parameter int NUM_PARTS   = 2,
    parameter int PRE_CYC     = 4,
    parameter int ERS_CYC     = 6,
    parameter int VFY_CYC     = 3,
    parameter logic [15:0] INIT_SEED = 16'hA5C3,
    localparam int WORDS = NUM_BLOCKS * BLOCK_WORDS,
    localparam int AW    = $clog2(WORDS),
    localparam int BKW   = $clog2(NUM_BLOCKS),
    localparam int PTW   = $clog2(NUM_PARTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [15:0]           wr_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [15:0]           rd_data,
    input  logic [NUM_BLOCKS-1:0] blk_lock,
    input  logic                  vpp_ok,
    input  logic                  prog_susp
);
    typedef struct packed {
        logic                       pend;
        logic                       e_ers;
        logic                       e_seq;
        logic                       e_vpp;
        logic                       e_lock;
        rmode_e [NUM_PARTS-1:0]     rmode;
    } cui_t;

    cui_t st_d, st_q;

    logic           busy, done, err_vpp, err_lock, err_vfy;
    logic           fill_en, blk_ones, start;
    logic [15:0]    fill_val, arr_data, status;
    logic [BKW-1:0] seq_blk, wr_blk;
    logic [PTW-1:0] wr_part, rd_part;

    assign wr_blk  = wr_addr[AW-1 -: BKW];
    assign wr_part = wr_addr[AW-1 -: PTW];
    assign rd_part = rd_addr[AW-1 -: PTW];

    assign status = {8'h00, !busy, 1'b0, st_q.e_ers, st_q.e_seq, st_q.e_vpp, 1'b0, st_q.e_lock, 1'b0};

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (done) begin
            if (err_vpp)  begin st_d.e_vpp  = 1'b1; st_d.e_ers = 1'b1; end
            if (err_lock) begin st_d.e_lock = 1'b1; st_d.e_ers = 1'b1; end
            if (err_vfy)  st_d.e_ers = 1'b1;
        end
        if (wr_en) begin
            if (busy) begin
                case (wr_data)
                    CMD_RD_ARRAY:           st_d.rmode[wr_part] = RM_ARRAY;
                    CMD_RD_STATUS:          st_d.rmode[wr_part] = RM_STATUS;
                    CMD_RD_INFO, CMD_QUERY: st_d.rmode[wr_part] = RM_INFO;
                    default: ;
                endcase
            end else if (st_q.pend) begin
                st_d.pend = 1'b0;
                if (wr_data == CMD_CONFIRM && !prog_susp) begin
                    start               = 1'b1;
                    st_d.rmode[wr_part] = RM_STATUS;
                end else begin
                    st_d.e_seq = 1'b1;
                    st_d.e_ers = 1'b1;
                end
            end else begin
                case (wr_data)
                    CMD_RD_ARRAY:           st_d.rmode[wr_part] = RM_ARRAY;
                    CMD_RD_STATUS:          st_d.rmode[wr_part] = RM_STATUS;
                    CMD_RD_INFO, CMD_QUERY: st_d.rmode[wr_part] = RM_INFO;
                    CMD_CLEAR: begin
                        st_d.e_ers  = 1'b0;
                        st_d.e_seq  = 1'b0;
                        st_d.e_vpp  = 1'b0;
                        st_d.e_lock = 1'b0;
                    end
                    CMD_SETUP:              st_d.pend = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (st_q.rmode[rd_part])
            RM_ARRAY:  rd_data = arr_data;
            RM_STATUS: rd_data = status;
            default:   rd_data = 16'h0000;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend   <= 1'b0;
            st_q.e_ers  <= 1'b0;
            st_q.e_seq  <= 1'b0;
            st_q.e_vpp  <= 1'b0;
            st_q.e_lock <= 1'b0;
            for (int p = 0; p < NUM_PARTS; p++) begin
                st_q.rmode[p] <= RM_ARRAY;
            end
        end else begin
            st_q <= st_d;
        end
    end

    erase_seq #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .PRE_CYC    (PRE_CYC),
        .ERS_CYC    (ERS_CYC),
        .VFY_CYC    (VFY_CYC)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .start_blk_i (wr_blk),
        .vpp_ok_i    (vpp_ok),
        .lock_i      (blk_lock),
        .blk_ones_i  (blk_ones),
        .busy_o      (busy),
        .blk_o       (seq_blk),
        .done_o      (done),
        .err_vpp_o   (err_vpp),
        .err_lock_o  (err_lock),
        .err_vfy_o   (err_vfy),
        .fill_en_o   (fill_en),
        .fill_val_o  (fill_val)
    );

    erase_array #(
        .NUM_BLOCKS  (NUM_BLOCKS),
        .BLOCK_WORDS (BLOCK_WORDS),
        .INIT_SEED   (INIT_SEED)
    ) i_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_en),
        .fill_blk (seq_blk),
        .fill_val (fill_val),
        .rd_addr  (rd_addr),
        .rd_data  (arr_data),
        .chk_blk  (seq_blk),
        .chk_ones (blk_ones)
    );

    // R1
    confirm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && st_q.pend && wr_en && wr_data == CMD_CONFIRM && !prog_susp) |=> busy);

    // R5
    vpp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !vpp_ok) |=> (status[7] && status[3] && status[5]));

    // R4
    lock_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && vpp_ok && blk_lock[seq_blk]) |=> (status[7] && status[1] && status[5]));

    // R6
    seq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && st_q.pend && wr_en && wr_data != CMD_CONFIRM) |=> (status[4] && status[5] && !busy));

    // R8
    busy_clear_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && wr_en && wr_data == CMD_CLEAR) |=> $stable(status[5:1]));

    // R9
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !st_q.pend && wr_en && wr_data == CMD_CLEAR) |=> (status[5:1] == 5'b0));
endmodule

// File: tb/test_flash_erase_ctrl.sv
`timescale 1ns/1ps
module test_flash_erase_ctrl;
    localparam int NB = 4, BW = 8, WORDS = 32, AW = 5;
    localparam int PRE = 4, ERS = 6, VFY = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic [NB-1:0] blk_lock = '0;
    logic          vpp_ok = 1'b1;
    logic          prog_susp = 1'b0;

    logic [15:0] exp_mem [WORDS];
    int vecs = 0;
    int bad  = 0;

    always #4 clk = ~clk;

    flash_erase_ctrl i_flash_erase_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .blk_lock(blk_lock), .vpp_ok(vpp_ok),
        .prog_susp(prog_susp)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        rd_addr = AW'(a);
        #0.2;
        v = rd_data;
    endtask

    task automatic sweep(input string req);
        logic [15:0] v;
        wr(0, 16'h00FF);
        wr(16, 16'h00FF);
        for (int i = 0; i < WORDS; i++) begin
            rd(i, v);
            chk(req, v, exp_mem[i]);
        end
    endtask

    task automatic stat(input int part, output logic [15:0] v);
        wr(part * 16, 16'h0070);
        rd(part * 16, v);
    endtask

    task automatic wait_ready(input int part, output int n);
        n = 0;
        rd_addr = AW'(part * 16);
        #0.2;
        while (rd_data[7] !== 1'b1 && n < 1000) begin
            @(negedge clk);
            #0.2;
            n++;
        end
    endtask

    task automatic erase(input int blk, output int n);
        wr(blk * BW, 16'h0020);
        wr(blk * BW + 3, 16'h00D0);
        wait_ready(blk / 2, n);
    endtask

    task automatic mark_erased(input int blk);
        for (int j = 0; j < BW; j++) exp_mem[blk * BW + j] = 16'hFFFF;
    endtask

    initial begin
        #(8 * 100000);
        vecs++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        for (int i = 0; i < WORDS; i++) begin
            logic [31:0] p;
            p = 32'(i) * 32'h111;
            exp_mem[i] = 16'hA5C3 ^ p[15:0];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 / R7: reset contents, array mode on both partitions
        for (int i = 0; i < WORDS; i++) begin
            rd(i, v);
            chk("R10", v, exp_mem[i]);
        end
        stat(0, v);
        chk("R1 reset status", v, 16'h0080);
        rd(16, v);
        chk("R7 other partition array", v, exp_mem[16]);
        wr(16, 16'h0090);
        rd(20, v);
        chk("R7 info mode", v, 16'h0000);
        rd(0, v);
        chk("R7 partition 0 untouched", v, 16'h0080);
        wr(16, 16'h0098);
        rd(17, v);
        chk("R7 query mode", v, 16'h0000);

        // R4: locked block
        blk_lock = 4'b0010;
        erase(1, n);
        chk("R4 abort cycles", 16'(n), 16'd1);
        rd(0, v);
        chk("R4 status", v, 16'h00A2);
        blk_lock = '0;
        sweep("R4 array unchanged");
        wr(0, 16'h0050);
        stat(0, v);
        chk("R9 clear", v, 16'h0080);

        // R6: bad confirm and confirm under program suspend
        wr(0, 16'h0020);
        wr(0, 16'h0040);
        rd(0, v);
        chk("R6 bad confirm", v, 16'h00B0);
        wr(0, 16'h0050);
        wr(8, 16'h0020);
        prog_susp = 1'b1;
        wr(11, 16'h00D0);
        prog_susp = 1'b0;
        rd(0, v);
        chk("R6 suspend confirm", v, 16'h00B0);
        sweep("R6 no erase");
        wr(0, 16'h0050);

        // R5: supply fault during precondition
        wr(16, 16'h0020);
        wr(17, 16'h00D0);
        @(negedge clk);
        vpp_ok = 1'b0;
        @(negedge clk);
        vpp_ok = 1'b1;
        rd(16, v);
        chk("R5 status", v, 16'h00A8);
        sweep("R5 array unchanged");
        wr(16, 16'h0050);

        // R8 / R9: sticky error, commands ignored while busy
        wr(0, 16'h0020);
        wr(0, 16'h0011);
        wr(24, 16'h0020);
        wr(24, 16'h00D0);
        wr(24, 16'h0050);
        wr(0, 16'h0020);
        wr(8, 16'h00D0);
        wait_ready(1, n);
        rd(24, v);
        chk("R8 clear ignored while busy", v, 16'h00B0);
        mark_erased(3);
        sweep("R8 single erase");
        wr(0, 16'h0050);
        stat(0, v);
        chk("R9 clear after", v, 16'h0080);

        // R2: observe the all-zero middle state of block 0
        wr(0, 16'h0020);
        wr(5, 16'h00D0);
        wr(0, 16'h00FF);
        rd(2, v);
        chk("R2 precondition in progress", v, exp_mem[2]);
        repeat (PRE) @(negedge clk);
        rd(0, v);
        chk("R2 zero after precondition", v, 16'h0000);
        rd(7, v);
        chk("R2 zero after precondition", v, 16'h0000);
        rd(16, v);
        chk("R7 other partition array while busy", v, exp_mem[16]);
        wr(0, 16'h0070);
        wait_ready(0, n);
        rd(0, v);
        chk("R3 status", v, 16'h0080);
        mark_erased(0);
        sweep("R3 block 0");

        // R2 / R3: exact duration for the rest
        for (int b = 1; b < 3; b++) begin
            erase(b, n);
            chk("R2 busy cycles", 16'(n), 16'(PRE + ERS + VFY));
            rd(b / 2 * 16, v);
            chk("R3 status", v, 16'h0080);
            mark_erased(b);
            sweep("R3 contents");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule